// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This block carries out one atomic store-class operation at a time against a single-port synchronous memory that it contains. A caller pulses `start` together with the access size, the low bits of the destination register, a signed 16-bit displacement, the source register value, the 32-bit operation immediate and the current value of R0. The unit computes the effective address and checks that the request is legal. It then reads the addressed memory line, forms the new value, writes it back and finishes with a one-cycle `done` pulse. From the read through the write it holds `lock` high, so that outside logic can keep other masters off the memory.

The immediate selects add, or, and or xor, each with an optional fetch modifier. It can also select exchange or compare-exchange. When the old memory value has to be returned, the unit presents it on `wb_data` and raises `wb_valid`. `wb_to_r0` then tells the caller which register to update: the source register or R0. A request it cannot execute ends at once with `illegal` and `done`, and the memory is left untouched.

Memory is organised as 64-bit lines. A word access works on the low or the high half of a line, chosen by address bit 2, and leaves the other half as it was.

Top module: `atomic_rmw_unit`

## Requirements
- R1: After reset `done`, `lock`, `illegal` and `wb_valid` are 0 and `wb_data` is zero, and they stay that way until a start is accepted.
- R2: A size code other than word (2'b00) or doubleword (2'b11) is rejected (2'b01 halfword, 2'b10 byte). So is a word address whose bits [1:0] are not zero, or a doubleword address whose bits [2:0] are not zero. A rejected request raises `illegal` and `done` together one cycle after `start`, with `wb_valid` 0, and does not change memory.
- R3: Immediates 0x00, 0x40, 0x50 and 0xa0 write memory with old+src, old|src, old&src and old^src. At doubleword size the operation uses all 64 bits, and without the fetch bit there is no writeback (`wb_valid` 0 and `wb_data` 0 with `done`).
- R4: Immediate bit 0 (0x01) is the fetch bit. On 0x01, 0x41, 0x51 and 0xa1 the unit does the same as without it, and also returns the old memory value with `wb_valid` 1 and `wb_to_r0` 0, meaning the source register.
- R5: At word size only the 32-bit half chosen by address bit 2 is used and changed (1 selects bits [63:32]). Arithmetic wraps at 32 bits, only the low 32 bits of the source take part, the other half of the line keeps its value, and returned values are zero-extended to 64 bits.
- R6: Immediate 0xe1 (exchange) writes the source value to memory and returns the old value with `wb_to_r0` 0.
- R7: Immediate 0xf1 (compare-exchange) compares memory with R0, using only the low 32 bits at word size. On a match it writes the source value to memory. In both cases it returns the zero-extended old value with `wb_valid` 1 and `wb_to_r0` 1.
- R8: Any other immediate, including 0xe0, 0xf0 and any value with a bit set above bit 7, is rejected in the same way as in R2: `illegal` and `done` after one cycle, and memory unchanged.
- R9: The byte address is the destination bits plus the sign-extended offset, modulo 2^(ADDR_W+3). Bits [ADDR_W+2:3] select the line.
- R10: A legal request raises `done` four cycles after `start`. A compare-exchange mismatch, which skips the write, raises it after three. `lock` is 1 in every cycle between the start and `done` and is 0 while `done` is 1. A `start` that arrives while the unit is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts an operation when the unit is idle |
| size | input | 2 | Access size code: 00 word, 01 halfword, 10 byte, 11 doubleword |
| dst_addr | input | ADDR_W+3 | Low bits of the destination register |
| offset | input | 16 | Signed displacement added to `dst_addr` |
| src_val | input | 64 | Source register value |
| op_imm | input | 32 | Operation immediate |
| r0_val | input | 64 | R0 value used by compare-exchange |
| lock | output | 1 | Memory held for the unit, from read through write |
| done | output | 1 | One-cycle end-of-operation pulse |
| illegal | output | 1 | Request rejected, valid together with `done` |
| wb_valid | output | 1 | `wb_data` carries a value to write back |
| wb_to_r0 | output | 1 | Writeback target: 1 means R0, 0 means the source register |
| wb_data | output | 64 | Old memory value, zero-extended at word size |

## Verification
The bench builds the unit with ADDR_W = 3, which gives eight 64-bit lines and a 6-bit byte address. With such a small space, an offset that runs past the top of memory wraps around to a low line, and a negative offset reaches a line below the base. A final sweep of fetching exchanges then reads every line back in a few operations. That sweep shows whether rejected requests, ignored starts and compare-exchange mismatches left memory untouched, and whether word writes disturbed the other half of their line.

// File: rtl/atomic_rmw_pkg.sv
`timescale 1ns/1ps
package atomic_rmw_pkg;
  localparam int XLEN = 64;
  localparam int HALF = XLEN / 2;

  localparam logic [1:0] SZ_WORD  = 2'b00;
  localparam logic [1:0] SZ_DWORD = 2'b11;

  typedef enum logic [2:0] {
    K_ADD, K_OR, K_AND, K_XOR, K_XCHG, K_CMPX
  } rmw_kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_READ, S_MODIFY, S_WRITE, S_DONE
  } rmw_state_e;
endpackage

// File: rtl/rmw_decode.sv
`timescale 1ns/1ps
module rmw_decode
  import atomic_rmw_pkg::*;
(
  input  logic [31:0] imm,
  input  logic [1:0]  size,
  output rmw_kind_e   kind,
  output logic        fetch,
  output logic        is_word,
  output logic        bad
);
  logic op_ok;

  always_comb begin
    kind  = K_ADD;
    op_ok = 1'b1;
    unique case (imm[7:1])
      7'h00:   kind = K_ADD;
      7'h20:   kind = K_OR;
      7'h28:   kind = K_AND;
      7'h50:   kind = K_XOR;
      7'h70: begin kind = K_XCHG; op_ok = imm[0]; end
      7'h78: begin kind = K_CMPX; op_ok = imm[0]; end
      default: op_ok = 1'b0;
    endcase
    if (imm[31:8] != 24'd0) op_ok = 1'b0;
  end

  assign fetch   = imm[0];
  assign is_word = (size == SZ_WORD);
  assign bad     = !op_ok || !((size == SZ_WORD) || (size == SZ_DWORD));
endmodule

// File: rtl/rmw_alu.sv
`timescale 1ns/1ps
module rmw_alu
  import atomic_rmw_pkg::*;
(
  input  rmw_kind_e        kind,
  input  logic             is_word,
  input  logic             hi,
  input  logic [XLEN-1:0]  line,
  input  logic [XLEN-1:0]  src,
  input  logic [XLEN-1:0]  cmp,
  output logic [XLEN-1:0]  old,
  output logic [XLEN-1:0]  new_line,
  output logic             match
);
  logic [HALF-1:0] half;
  logic [XLEN-1:0] s_op, c_op, res;

  assign half = hi ? line[XLEN-1:HALF] : line[HALF-1:0];
  assign old  = is_word ? {{HALF{1'b0}}, half} : line;
  assign s_op = is_word ? {{HALF{1'b0}}, src[HALF-1:0]} : src;
  assign c_op = is_word ? {{HALF{1'b0}}, cmp[HALF-1:0]} : cmp;

  always_comb begin
    unique case (kind)
      K_ADD:   res = old + s_op;
      K_OR:    res = old | s_op;
      K_AND:   res = old & s_op;
      K_XOR:   res = old ^ s_op;
      K_XCHG,
      K_CMPX:  res = s_op;
      default: res = old;
    endcase
  end

  assign match = (old == c_op);

  always_comb begin
    if (!is_word)  new_line = res;
    else if (hi)   new_line = {res[HALF-1:0], line[HALF-1:0]};
    else           new_line = {line[XLEN-1:HALF], res[HALF-1:0]};
  end
endmodule

// File: rtl/rmw_ram.sv
`timescale 1ns/1ps
module rmw_ram #(
  parameter int AW = 4,
  parameter int DW = 64,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/atomic_rmw_unit.sv
`timescale 1ns/1ps
module atomic_rmw_unit
  import atomic_rmw_pkg::*;
#(
  parameter int ADDR_W = 4,
  localparam int AB = ADDR_W + 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [1:0]      size,
  input  logic [AB-1:0]   dst_addr,
  input  logic [15:0]     offset,
  input  logic [XLEN-1:0] src_val,
  input  logic [31:0]     op_imm,
  input  logic [XLEN-1:0] r0_val,
  output logic            lock,
  output logic            done,
  output logic            illegal,
  output logic            wb_valid,
  output logic            wb_to_r0,
  output logic [XLEN-1:0] wb_data
);
  rmw_state_e st;
  rmw_kind_e  dec_kind, kind_q;
  logic       dec_fetch, dec_word, dec_bad, misaligned;
  logic       fetch_q, word_q;
  logic [AB-1:0]   eff_addr, addr_q;
  logic [XLEN-1:0] src_q, r0_q, old_q, line_q;
  logic [XLEN-1:0] ram_rdata, alu_old, alu_line;
  logic            alu_match, ram_we;

  rmw_decode u_dec (
    .imm(op_imm), .size(size), .kind(dec_kind),
    .fetch(dec_fetch), .is_word(dec_word), .bad(dec_bad)
  );

  assign eff_addr   = dst_addr + AB'($signed(offset));
  assign misaligned = dec_word ? (eff_addr[1:0] != 2'b00) : (eff_addr[2:0] != 3'b000);

  rmw_ram #(.AW(ADDR_W), .DW(XLEN)) u_ram (
    .clk(clk), .we(ram_we), .addr(addr_q[AB-1:3]),
    .wdata(line_q), .rdata(ram_rdata)
  );

  rmw_alu u_alu (
    .kind(kind_q), .is_word(word_q), .hi(addr_q[2]), .line(ram_rdata),
    .src(src_q), .cmp(r0_q), .old(alu_old), .new_line(alu_line), .match(alu_match)
  );

  assign ram_we = (st == S_WRITE);
  assign lock   = (st == S_READ) || (st == S_MODIFY) || (st == S_WRITE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      kind_q   <= K_ADD;
      fetch_q  <= 1'b0;
      word_q   <= 1'b0;
      addr_q   <= '0;
      src_q    <= '0;
      r0_q     <= '0;
      old_q    <= '0;
      line_q   <= '0;
      done     <= 1'b0;
      illegal  <= 1'b0;
      wb_valid <= 1'b0;
      wb_to_r0 <= 1'b0;
      wb_data  <= '0;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (start) begin
            kind_q  <= dec_kind;
            fetch_q <= dec_fetch;
            word_q  <= dec_word;
            addr_q  <= eff_addr;
            src_q   <= src_val;
            r0_q    <= r0_val;
            if (dec_bad || misaligned) begin
              st      <= S_DONE;
              done    <= 1'b1;
              illegal <= 1'b1;
            end else begin
              st <= S_READ;
            end
          end
        end
        S_READ: st <= S_MODIFY;
        S_MODIFY: begin
          old_q  <= alu_old;
          line_q <= alu_line;
          if (kind_q == K_CMPX && !alu_match) begin
            st       <= S_DONE;
            done     <= 1'b1;
            wb_valid <= 1'b1;
            wb_to_r0 <= 1'b1;
            wb_data  <= alu_old;
          end else begin
            st <= S_WRITE;
          end
        end
        S_WRITE: begin
          st       <= S_DONE;
          done     <= 1'b1;
          wb_valid <= fetch_q;
          wb_to_r0 <= (kind_q == K_CMPX);
          wb_data  <= fetch_q ? old_q : '0;
        end
        S_DONE: begin
          st       <= S_IDLE;
          done     <= 1'b0;
          illegal  <= 1'b0;
          wb_valid <= 1'b0;
          wb_to_r0 <= 1'b0;
          wb_data  <= '0;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rmw_checker.sv
`timescale 1ns/1ps
module rmw_checker (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic [1:0] size,
  input logic       lock,
  input logic       done,
  input logic       illegal,
  input logic       wb_valid,
  input logic       ram_we
);
  a_r10_done_unlocked: assert property (@(posedge clk) disable iff (rst)
    done |-> !lock);

  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r10_locked_before_done: assert property (@(posedge clk) disable iff (rst)
    ($rose(done) && !illegal) |-> $past(lock));

  a_r2_illegal_with_done: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (done && !wb_valid));

  a_r4_wb_with_done: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> done);

  a_r8_write_only_locked: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> lock);

  a_r2_bad_size_rejected: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && start && !lock && !done && (size == 2'b01 || size == 2'b10))
      |-> (done && illegal));
endmodule

bind atomic_rmw_unit rmw_checker u_chk (
  .clk(clk), .rst(rst), .start(start), .size(size), .lock(lock),
  .done(done), .illegal(illegal), .wb_valid(wb_valid), .ram_we(ram_we)
);

// File: tb/atomic_rmw_unit_test.sv
`timescale 1ns/1ps
module atomic_rmw_unit_test;
  localparam int AW = 3;
  localparam int AB = AW + 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [1:0]    size = 2'b00;
  logic [AB-1:0] dst_addr = '0;
  logic [15:0]   offset = '0;
  logic [63:0]   src_val = '0;
  logic [31:0]   op_imm = '0;
  logic [63:0]   r0_val = '0;
  logic          lock, done, illegal, wb_valid, wb_to_r0;
  logic [63:0]   wb_data;

  atomic_rmw_unit #(.ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .start(start), .size(size), .dst_addr(dst_addr),
    .offset(offset), .src_val(src_val), .op_imm(op_imm), .r0_val(r0_val),
    .lock(lock), .done(done), .illegal(illegal), .wb_valid(wb_valid),
    .wb_to_r0(wb_to_r0), .wb_data(wb_data)
  );

  always #5 clk = ~clk;

  typedef struct {
    string       tag;
    int          lat;
    int          spc;
    logic        ill;
    logic        wbv;
    logic        to_r0;
    logic [63:0] data;
  } exp_t;

  exp_t        sb[$];
  logic [63:0] mdl [8];
  int          pc = 0;
  int          n_checks = 0;
  int          n_errors = 0;

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // monitor: samples 2 ns after each rising edge
  always @(posedge clk) begin
    pc++;
    #2;
    if (!rst && done) begin
      if (sb.size() == 0) begin
        check("R10", "unexpected done", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, "latency", 64'(pc - e.spc), 64'(e.lat));
        check(e.tag, "illegal", {63'd0, illegal}, {63'd0, e.ill});
        check(e.tag, "wb_valid", {63'd0, wb_valid}, {63'd0, e.wbv});
        check(e.tag, "wb_to_r0", {63'd0, wb_to_r0}, {63'd0, e.to_r0});
        check(e.tag, "wb_data", wb_data, e.data);
        check("R10", "lock at done", {63'd0, lock}, 64'd0);
      end
    end
  end

  task automatic run(input string tag, input logic [1:0] sz, input logic [AB-1:0] dst,
                     input logic [15:0] off, input logic [63:0] src, input logic [31:0] imm,
                     input logic [63:0] r0, input int hold, input bit chk_lock);
    exp_t e;
    logic [AB-1:0] ea;
    logic legal, word, m, cmpx;
    logic [63:0] line, old, s, c, res;
    ea    = dst + off[AB-1:0];
    word  = (sz == 2'b00);
    cmpx  = (imm == 32'hf1);
    legal = (sz == 2'b00 || sz == 2'b11) &&
            (word ? ea[1:0] == 0 : ea[2:0] == 0) &&
            (imm inside {32'h00, 32'h01, 32'h40, 32'h41, 32'h50, 32'h51,
                         32'ha0, 32'ha1, 32'he1, 32'hf1});
    e.tag = tag; e.ill = 0; e.wbv = 0; e.to_r0 = 0; e.data = 0;
    if (!legal) begin
      e.lat = 1; e.ill = 1;
    end else begin
      line = mdl[ea[5:3]];
      old  = word ? {32'd0, (ea[2] ? line[63:32] : line[31:0])} : line;
      s    = word ? {32'd0, src[31:0]} : src;
      c    = word ? {32'd0, r0[31:0]} : r0;
      case (imm[7:4])
        4'h0:    res = old + s;
        4'h4:    res = old | s;
        4'h5:    res = old & s;
        4'ha:    res = old ^ s;
        default: res = s;
      endcase
      m = (old == c);
      if (cmpx && !m) begin
        e.lat = 3; e.wbv = 1; e.to_r0 = 1; e.data = old;
      end else begin
        e.lat = 4;
        if (!word)      mdl[ea[5:3]] = res;
        else if (ea[2]) mdl[ea[5:3]] = {res[31:0], line[31:0]};
        else            mdl[ea[5:3]] = {line[63:32], res[31:0]};
        e.wbv = imm[0]; e.to_r0 = cmpx; e.data = imm[0] ? old : 64'd0;
      end
    end
    @(negedge clk);
    e.spc = pc;
    sb.push_back(e);
    start = 1; size = sz; dst_addr = dst; offset = off;
    src_val = src; op_imm = imm; r0_val = r0;
    for (int i = 1; i <= e.lat; i++) begin
      @(negedge clk);
      if (i >= hold) start = 0;
      if (chk_lock) begin
        if (i < e.lat) check("R10", "lock while busy", {63'd0, lock}, 64'd1);
        else           check("R10", "lock released", {63'd0, lock}, 64'd0);
      end
    end
    while (sb.size() != 0) @(negedge clk);
    start = 0;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mdl[i] = 64'd0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk); @(negedge clk);
    check("R1", "done after reset", {63'd0, done}, 64'd0);
    check("R1", "lock after reset", {63'd0, lock}, 64'd0);
    check("R1", "illegal after reset", {63'd0, illegal}, 64'd0);
    check("R1", "wb_valid after reset", {63'd0, wb_valid}, 64'd0);
    check("R1", "wb_data after reset", wb_data, 64'd0);

    // R6 exchange fills lines
    run("R6", 2'b11, 6'h00, 16'h0000, 64'h1122334455667788, 32'he1, 0, 1, 1);
    run("R6", 2'b11, 6'h00, 16'h0000, 64'hf0f0f0f00f0f0f0f, 32'he1, 0, 1, 0);
    run("R6", 2'b11, 6'h08, 16'h0000, 64'hffffffff_fffffffe, 32'he1, 0, 1, 0);
    // R3 simple ops without fetch
    run("R3", 2'b11, 6'h00, 16'h0000, 64'h0000000100000001, 32'h00, 0, 1, 0);
    run("R3", 2'b11, 6'h00, 16'h0000, 64'h0000ffff00000000, 32'h40, 0, 1, 0);
    run("R3", 2'b11, 6'h00, 16'h0000, 64'hff00ff00ff00ff00, 32'h50, 0, 1, 0);
    run("R3", 2'b11, 6'h00, 16'h0000, 64'h5555aaaa5555aaaa, 32'ha0, 0, 1, 0);
    // R4 fetch variants
    run("R4", 2'b11, 6'h00, 16'h0000, 64'h8000000000000001, 32'h01, 0, 1, 0);
    run("R4", 2'b11, 6'h08, 16'h0000, 64'h0000000000000003, 32'h01, 0, 1, 0);
    run("R4", 2'b11, 6'h00, 16'h0000, 64'h0f, 32'h41, 0, 1, 0);
    run("R4", 2'b11, 6'h00, 16'h0000, 64'hffff0000ffff0000, 32'h51, 0, 1, 0);
    run("R4", 2'b11, 6'h00, 16'h0000, 64'h123456789abcdef0, 32'ha1, 0, 1, 0);
    // R5 word halves
    run("R5", 2'b00, 6'h10, 16'h0000, 64'hdeadbeef_ffffffff, 32'he1, 0, 1, 0);
    run("R5", 2'b00, 6'h10, 16'h0000, 64'h12345678_00000002, 32'h01, 0, 1, 0);
    run("R5", 2'b00, 6'h14, 16'h0000, 64'hcafef00d_a5a5a5a5, 32'he1, 0, 1, 0);
    run("R5", 2'b00, 6'h14, 16'h0000, 64'h00000000_0000ffff, 32'ha1, 0, 1, 0);
    run("R5", 2'b00, 6'h10, 16'h0000, 64'h0, 32'h41, 0, 1, 0);
    // R7 compare-exchange
    run("R7", 2'b11, 6'h08, 16'h0000, 64'h7777, 32'hf1, 64'h1, 1, 0);
    run("R7", 2'b11, 6'h08, 16'h0000, 64'h9999, 32'hf1, 64'h7777, 1, 0);
    run("R7", 2'b00, 6'h14, 16'h0000, 64'h11111111, 32'hf1, 64'hffffffff_a5a55a5a, 1, 0);
    run("R7", 2'b00, 6'h14, 16'h0000, 64'h22222222, 32'hf1, 64'h00000000_12345678, 1, 0);
    run("R7", 2'b00, 6'h14, 16'h0000, 64'h33333333, 32'hf1, 64'h00000000_11111111, 1, 1);
    // R2 bad size and misalignment
    run("R2", 2'b01, 6'h00, 16'h0000, 64'h1, 32'h00, 0, 1, 0);
    run("R2", 2'b10, 6'h00, 16'h0000, 64'h1, 32'he1, 0, 1, 0);
    run("R2", 2'b11, 6'h04, 16'h0000, 64'h1, 32'he1, 0, 1, 0);
    run("R2", 2'b00, 6'h12, 16'h0000, 64'h1, 32'he1, 0, 1, 0);
    // R8 bad immediates
    run("R8", 2'b11, 6'h00, 16'h0000, 64'h1, 32'he0, 0, 1, 0);
    run("R8", 2'b11, 6'h00, 16'h0000, 64'h1, 32'hf0, 64'h0, 1, 0);
    run("R8", 2'b11, 6'h00, 16'h0000, 64'h1, 32'h10, 0, 1, 0);
    run("R8", 2'b11, 6'h00, 16'h0000, 64'h1, 32'h101, 0, 1, 0);
    // R9 offsets: negative, and wrap past the top
    run("R9", 2'b11, 6'h30, 16'hfff8, 64'habcdef01_23456789, 32'he1, 0, 1, 0);
    run("R9", 2'b11, 6'h38, 16'h0010, 64'h0102030405060708, 32'he1, 0, 1, 0);
    run("R9", 2'b11, 6'h28, 16'h0000, 64'h0, 32'h01, 0, 1, 0);
    // R10 start held while busy is ignored
    run("R10", 2'b11, 6'h20, 16'h0000, 64'h00ff00ff00ff00ff, 32'ha0, 0, 4, 0);
    run("R10", 2'b11, 6'h18, 16'h0000, 64'h5, 32'h00, 0, 4, 1);
    // readback sweep
    for (int i = 0; i < 8; i++)
      run("R9", 2'b11, 6'(i * 8), 16'h0000, 64'h0, 32'he1, 0, 1, 0);

    repeat (5) @(negedge clk);
    check("R10", "pending results", 64'(sb.size()), 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #500000;
    n_checks++;
    n_errors++;
    $display("FAIL R10 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule